// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a baud-rate enable from the system clock by fractional phase accumulation. On every clock edge a fixed tuning word is added to a binary accumulator. The most significant bit of the accumulator is a square wave at the baud rate. A one-clock enable pulse marks each baud period, so serial shift logic running on the same clock can advance once per bit. No derived clock is produced, and all logic stays in the system clock domain.

The accumulator width and the tuning word are computed at elaboration time from two parameters, the clock frequency and the baud rate. Let the index of the top accumulator bit be `MSB = round(log2((CLK_HZ/BAUD_HZ)^2))`. The accumulator is then `MSB+1` bits wide, and the step is `round(BAUD_HZ * 2^(MSB+1) / CLK_HZ)`.

A parameter selects the source of the pulse. The first source is a registered rising-edge detector on the accumulator MSB. The second is the carry out of the addition, captured in the same edge as the new sum.

Top module: `baud_tick_gen`

## Requirements
- R1: With the default parameters (CLK_HZ = 100000000, BAUD_HZ = 115200), the accumulator top bit index is 20 (21-bit accumulator) and the step is 2416. Consecutive pulses are therefore 868 or 869 clocks apart.
- R2: After reset is released, the accumulator holds `k*STEP mod 2^(MSB+1)` after the k-th clock edge. `sq_o` is bit MSB of that value, which equals `floor(k*STEP / 2^MSB) mod 2`.
- R3: In edge mode (`TICK_SRC` = 0), the total count of `tick_o` pulses seen after edge k (k >= 1) is `floor(((k-1)*STEP + 2^MSB) / 2^(MSB+1))`. This places each pulse one clock after the rise of `sq_o` is registered.
- R4: In carry mode (`TICK_SRC` = 1), the total count of `tick_o` pulses after edge k is `floor(k*STEP / 2^(MSB+1))`. During a pulse, `sq_o` is low.
- R5: `tick_o` is never high on two consecutive clocks.
- R6: The gap between two successive pulses, in clocks, is always floor or ceil of `2^(MSB+1)/STEP`.
- R7: `rst` is synchronous and active high. It clears the accumulator and the pulse state, so `tick_o` and `sq_o` are 0 in the cycle after any edge at which `rst` was high.
- R8: `tick_o` stays low after the first clock edge that follows reset release. A stale registered bit therefore cannot produce a false pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_o | output | 1 | One-clock enable pulse, one per baud period |
| sq_o | output | 1 | Accumulator top bit, a square wave at the baud rate |

## Verification
Every result is a function of k, the number of clock edges since reset release.

- `sq_o` reflects the accumulator value after edge k in the same cycle.
- The carry-mode pulse for step k is visible right after edge k.
- The edge-mode pulse for a rise at accumulator state k-1 is visible only after edge k, because it passes the MSB register, the delay register and the pulse register.

The bench counts k itself from its own reset stimulus and samples on the falling clock edge. It compares running pulse totals against closed-form floor expressions at that offset on every cycle, which means a pulse that arrives one clock early or late is reported at once.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  typedef enum logic {
    SRC_MSB_EDGE = 1'b0,
    SRC_CARRY    = 1'b1
  } tick_src_e;

  // Index of the accumulator top bit: round(log2(ratio^2)).
  function automatic int calc_msb_idx(input real clk_hz, input real baud_hz);
    real ratio;
    ratio = clk_hz / baud_hz;
    return $rtoi($ln(ratio * ratio) / $ln(2.0) + 0.5);
  endfunction

  // Step added each clock: round(baud * 2^(msb+1) / clk).
  function automatic int calc_step(input real clk_hz, input real baud_hz,
                                   input int msb_idx);
    return $rtoi(baud_hz * (2.0 ** (msb_idx + 1)) / clk_hz + 0.5);
  endfunction

endpackage

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int ACC_W = 21,
  parameter int STEP  = 2416
) (
  input  logic clk,
  input  logic rst,
  output logic acc_msb,
  output logic carry_nxt
);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  // Extend by one bit so the wrap shows up as a carry.
  assign sum       = {1'b0, acc_q} + {1'b0, STEP_V};
  assign carry_nxt = sum[ACC_W];
  assign acc_msb   = acc_q[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/baud_tick_detect.sv
module baud_tick_detect
  import baud_tick_pkg::*;
#(
  parameter tick_src_e TICK_SRC = SRC_MSB_EDGE
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_msb,
  input  logic carry_nxt,
  output logic tick_o
);
  logic tick_q;
  assign tick_o = tick_q;

  generate
    if (TICK_SRC == SRC_MSB_EDGE) begin : g_edge
      logic msb_q;
      logic primed_q;
      logic unused_carry;
      assign unused_carry = carry_nxt;
      always_ff @(posedge clk) begin
        if (rst) begin
          msb_q    <= 1'b0;
          primed_q <= 1'b0;
          tick_q   <= 1'b0;
        end else begin
          msb_q    <= acc_msb;
          primed_q <= 1'b1;
          // A rise counts only once the delay register holds a real sample.
          tick_q   <= primed_q & acc_msb & ~msb_q;
        end
      end
    end else begin : g_carry
      logic unused_msb;
      assign unused_msb = acc_msb;
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= carry_nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int        CLK_HZ   = 100_000_000,
  parameter int        BAUD_HZ  = 115_200,
  parameter tick_src_e TICK_SRC = SRC_MSB_EDGE
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic sq_o
);
  localparam int MSB_IDX   = calc_msb_idx(real'(CLK_HZ), real'(BAUD_HZ));
  localparam int ACC_W     = MSB_IDX + 1;
  localparam int STEP_WORD = calc_step(real'(CLK_HZ), real'(BAUD_HZ), MSB_IDX);

  logic acc_msb;
  logic carry_nxt;

  baud_phase_acc #(
    .ACC_W (ACC_W),
    .STEP  (STEP_WORD)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .acc_msb   (acc_msb),
    .carry_nxt (carry_nxt)
  );

  baud_tick_detect #(
    .TICK_SRC (TICK_SRC)
  ) u_det (
    .clk       (clk),
    .rst       (rst),
    .acc_msb   (acc_msb),
    .carry_nxt (carry_nxt),
    .tick_o    (tick_o)
  );

  assign sq_o = acc_msb;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_tick_pkg::*;
#(
  parameter int        ACC_W    = 21,
  parameter int        STEP     = 2416,
  parameter tick_src_e TICK_SRC = SRC_MSB_EDGE
) (
  input logic clk,
  input logic rst,
  input logic tick_o,
  input logic sq_o
);
  localparam longint MODULUS = longint'(1) << ACC_W;
  localparam int     MIN_GAP = int'(MODULUS / longint'(STEP));

  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);  // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!tick_o && !sq_o));  // R7

  AST_QUIET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> !tick_o);  // R8

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && seen_q) |-> (gap_q + 32'd1 >= 32'(MIN_GAP)));  // R6

  generate
    if (TICK_SRC == SRC_MSB_EDGE) begin : g_edge_chk
      AST_RISE_GIVES_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(sq_o) |=> tick_o);  // R3
      AST_TICK_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(sq_o));  // R3
    end else begin : g_carry_chk
      AST_CARRY_SQ_LOW: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> !sq_o);  // R4
    end
  endgenerate
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .ACC_W    (ACC_W),
  .STEP     (STEP_WORD),
  .TICK_SRC (TICK_SRC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick_o (tick_o),
  .sq_o   (sq_o)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  import baud_tick_pkg::*;

  localparam int     CLK_P     = 10;
  localparam longint EXP_MSB   = 20;     // R1
  localparam longint EXP_STEP  = 2416;   // R1
  localparam longint EXP_MOD   = longint'(1) << (EXP_MSB + 1);
  localparam longint GAP_LO    = EXP_MOD / EXP_STEP;
  localparam longint GAP_HI    = (EXP_MOD + EXP_STEP - 1) / EXP_STEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_e, sq_e, tick_c, sq_c;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  baud_tick_gen #(.TICK_SRC(SRC_MSB_EDGE)) i_baud_tick_gen (
    .clk(clk), .rst(rst), .tick_o(tick_e), .sq_o(sq_e));

  baud_tick_gen #(.TICK_SRC(SRC_CARRY)) i_baud_tick_gen_cy (
    .clk(clk), .rst(rst), .tick_o(tick_c), .sq_o(sq_c));

  // Edges since reset release, counted from the bench's own stimulus.
  longint k = 0;
  bit     rst_at_edge = 1'b1;
  always @(posedge clk) begin
    rst_at_edge <= rst;
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  function automatic longint exp_edge_cnt(input longint kk);
    if (kk < 1) return 0;
    return ((kk - 1) * EXP_STEP + (EXP_MOD / 2)) / EXP_MOD;
  endfunction

  function automatic longint exp_carry_cnt(input longint kk);
    return (kk * EXP_STEP) / EXP_MOD;
  endfunction

  function automatic bit exp_sq(input longint kk);
    return bit'(((kk * EXP_STEP) / (EXP_MOD / 2)) % 2);
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      if (n_bad < 40)
        $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  longint cnt_e = 0, cnt_c = 0;
  longint last_e = -1, last_c = -1;
  bit     prev_e = 1'b0, prev_c = 1'b0;

  always @(negedge clk) begin
    if (rst_at_edge) begin
      // r7_ reset state
      check(!tick_e && !sq_e, "R7 edge-mode outputs in reset", {tick_e, sq_e}, 0);
      check(!tick_c && !sq_c, "R7 carry-mode outputs in reset", {tick_c, sq_c}, 0);
      cnt_e = 0; cnt_c = 0; last_e = -1; last_c = -1;
      prev_e = 1'b0; prev_c = 1'b0;
    end else begin
      if (k == 1) begin
        check(!tick_e, "R8 edge-mode quiet after release", tick_e, 0);
        check(!tick_c, "R8 carry-mode quiet after release", tick_c, 0);
      end
      if (tick_e) begin
        cnt_e++;
        check(!prev_e, "R5 edge-mode back-to-back", 1, 0);
        if (last_e >= 0)
          check((k - last_e == GAP_LO) || (k - last_e == GAP_HI),
                "R6 R1 edge-mode gap", k - last_e, GAP_LO);
        last_e = k;
      end
      if (tick_c) begin
        cnt_c++;
        check(!prev_c, "R5 carry-mode back-to-back", 1, 0);
        if (last_c >= 0)
          check((k - last_c == GAP_LO) || (k - last_c == GAP_HI),
                "R6 R1 carry-mode gap", k - last_c, GAP_LO);
        last_c = k;
        check(!sq_c, "R4 square low on carry pulse", sq_c, 0);
      end
      prev_e = tick_e;
      prev_c = tick_c;
      check(sq_e == exp_sq(k), "R2 edge-mode square", sq_e, exp_sq(k));
      check(sq_c == exp_sq(k), "R2 carry-mode square", sq_c, exp_sq(k));
      check(cnt_e == exp_edge_cnt(k), "R3 edge-mode pulse total", cnt_e, exp_edge_cnt(k));
      check(cnt_c == exp_carry_cnt(k), "R4 carry-mode pulse total", cnt_c, exp_carry_cnt(k));
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic apply_reset(input int len);
    @(negedge clk);
    rst = 1'b1;
    repeat (len) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0BAD);
    apply_reset(4);
    run_cycles(30000);                 // long run: many pulses, both modes
    apply_reset(1);                    // directed: one-cycle reset mid-run
    run_cycles(4000);
    for (int i = 0; i < 3; i++) begin  // random reset points and lengths
      run_cycles(int'($urandom_range(1, 900)));
      apply_reset(int'($urandom_range(1, 4)));
      run_cycles(int'($urandom_range(3000, 12000)));
    end
    apply_reset(2);                    // directed: reset near a pulse
    run_cycles(867);
    apply_reset(1);
    run_cycles(2000);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule